// File: doc/BRIEF.md
# Multi-Slot Inter-Processor Mailbox

This block is a register-mapped mailbox that lets a local processor and a peer microcontroller exchange short fixed-length messages. It holds a configurable number of one-way slots. Each slot has one mode word, which carries a one-hot slot state and an acknowledge-handling selector, followed by a run of 32-bit message words. The local processor reaches every slot and a small block of interrupt-control registers through a simple register bus with a registered read path. A second port stands for the peer. That port reads and writes slot contents and pulses per-slot acknowledge lines.

When the peer acknowledges a slot, the slot's acknowledge selector decides what happens. In automatic mode the slot returns to idle so that software can poll it, and no interrupt is raised. In interrupt mode the slot moves to the acknowledged state and sets a raw acknowledge bit. Raw bits are filtered by an enable vector, which software can set, clear or overwrite. The OR of the filtered bits drives one level-high interrupt to the local processor. A doorbell register raises one-hot request lines toward the peer, and the peer clears them.

Top module: `ipc_slot_mailbox`

## Requirements
- R1: After reset every slot's mode word reads 0x10 (state idle, interrupt-mode acknowledge), every message word reads 0, and the raw, enable and doorbell vectors are all zero, so `irq` is low.
- R2: Address bit 12 selects the region: 0 for the slots, 1 for the control registers. Slot s, word w sits at byte address s*0x40 + 4*w. Word 0 is the mode word and words 1..8 hold the message. Words 9..15 of a window read 0 and ignore writes. Read data appears on `l_rdata` one clock after the address is presented.
- R3: In the mode word, bits [7:4] hold the state (idle 0x1, transmit 0x2, receive 0x4, acknowledged 0x8) and bit 0 selects the acknowledge mode (1 = automatic idle, 0 = interrupt). All other bits read 0.
- R4: The remote port reads and writes the same slot storage. When both ports write the same word in the same cycle, the remote value is kept. Remote writes with address bit 12 set are ignored.
- R5: A pulse on `r_ack[s]` while slot s is in automatic mode sets that slot's state to idle (0x1), leaves the raw acknowledge vector unchanged and raises no interrupt.
- R6: A pulse on `r_ack[s]` while slot s is in interrupt mode sets raw bit s and sets that slot's state to acknowledged (0x8).
- R7: Writing to control offset 0x500 sets the enable bits given by the write data, and writing to 0x504 clears them. Writing to 0x404 replaces the whole enable vector. Offsets 0x404 and 0x500 read the enable vector. Offset 0x504 reads 0.
- R8: Offset 0x408 reads the raw vector ANDed with the enable vector, and `irq` is high exactly when that result is nonzero. Offset 0x400 reads the raw vector.
- R9: Writing ones to offset 0x40C clears the matching raw bits, and all ones clears every bit. An acknowledge that arrives in the same cycle as a clear of its bit wins. Offset 0x40C reads 0.
- R10: Writing to offset 0x420 sets the matching bits of `db_to_peer`. A pulse on `r_db_clr` clears the matching bits. Offset 0x420 reads the doorbell vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_addr | input | 13 | Local byte address; bit 12 selects the control region |
| l_we | input | 1 | Local write strobe |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, registered |
| r_addr | input | 13 | Remote byte address (slot region only) |
| r_we | input | 1 | Remote write strobe |
| r_wdata | input | 32 | Remote write data |
| r_rdata | output | 32 | Remote read data, registered |
| r_ack | input | 32 | Per-slot acknowledge pulses from the peer |
| r_db_clr | input | 32 | Peer clear of doorbell bits |
| db_to_peer | output | 32 | Doorbell request lines toward the peer |
| irq | output | 1 | Level-high interrupt to the local processor |

## Verification
Message words are written with a distinct value per word and per slot, so that an address-decode slip or a swapped window shows up as a wrong value. Out-of-window words are written to check that nothing aliases into a neighbouring slot. Acknowledges are sent to one slot in automatic mode and one in interrupt mode. After each, the state field, the raw vector and `irq` are read, which separates the two acknowledge paths. The enable vector is driven through set, clear and overwrite in turn, with `irq` checked after each step. Same-cycle collisions (local against remote write, clear against acknowledge) show which side takes priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // one-hot slot states held in mode word bits [7:4]
   localparam logic [3:0] ST_IDLE = 4'h1;
   localparam logic [3:0] ST_SEND = 4'h2;
   localparam logic [3:0] ST_RECV = 4'h4;
   localparam logic [3:0] ST_DONE = 4'h8;

   localparam int MODE_ST_LSB  = 4;
   localparam int MODE_ACK_BIT = 0;
   localparam int WIN_BYTES    = 64;
   localparam int WIN_WORDS    = WIN_BYTES / 4;

   // control-region offsets
   localparam logic [11:0] OFF_RAW  = 12'h400;
   localparam logic [11:0] OFF_MASK = 12'h404;
   localparam logic [11:0] OFF_STAT = 12'h408;
   localparam logic [11:0] OFF_CLR  = 12'h40C;
   localparam logic [11:0] OFF_DB   = 12'h420;
   localparam logic [11:0] OFF_EN   = 12'h500;
   localparam logic [11:0] OFF_DIS  = 12'h504;

   typedef enum logic [2:0] {
      CR_NONE, CR_RAW, CR_MASK, CR_STAT, CR_CLR, CR_DB, CR_EN, CR_DIS
   } ctrl_sel_e;

   function automatic ctrl_sel_e decode_ctrl(input logic [11:0] off);
      ctrl_sel_e sel;
      case (off)
         OFF_RAW:  sel = CR_RAW;
         OFF_MASK: sel = CR_MASK;
         OFF_STAT: sel = CR_STAT;
         OFF_CLR:  sel = CR_CLR;
         OFF_DB:   sel = CR_DB;
         OFF_EN:   sel = CR_EN;
         OFF_DIS:  sel = CR_DIS;
         default:  sel = CR_NONE;
      endcase
      return sel;
   endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot
   import mbx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MSG_WORDS = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             l_we,
   input  logic [3:0]                       l_word,
   input  logic [DATA_W-1:0]                l_wdata,
   input  logic                             r_we,
   input  logic [3:0]                       r_word,
   input  logic [DATA_W-1:0]                r_wdata,
   input  logic                             ack_in,
   output logic [MSG_WORDS:0][DATA_W-1:0]   words_o,
   output logic                             auto_o,
   output logic                             ack_irq_o
);
   logic [3:0] state_q;
   logic       auto_q;
   logic [MSG_WORDS-1:0][DATA_W-1:0] data_q;

   // mode word: local write, then remote overrides, then peer acknowledge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         auto_q  <= 1'b0;
      end else begin
         if (l_we && l_word == 4'd0) begin
            state_q <= l_wdata[MODE_ST_LSB +: 4];
            auto_q  <= l_wdata[MODE_ACK_BIT];
         end
         if (r_we && r_word == 4'd0) begin
            state_q <= r_wdata[MODE_ST_LSB +: 4];
            auto_q  <= r_wdata[MODE_ACK_BIT];
         end
         if (ack_in) begin
            state_q <= auto_q ? ST_IDLE : ST_DONE;
         end
      end
   end

   for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[w] <= '0;
         end else begin
            if (l_we && l_word == 4'(w + 1)) data_q[w] <= l_wdata;
            if (r_we && r_word == 4'(w + 1)) data_q[w] <= r_wdata;
         end
      end
      assign words_o[w+1] = data_q[w];
   end

   assign words_o[0] = DATA_W'({state_q, 3'b000, auto_q});
   assign auto_o     = auto_q;
   assign ack_irq_o  = ack_in & ~auto_q;
endmodule

// File: rtl/mbx_ack_irq.sv
module mbx_ack_irq #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ack_set,
   input  logic         clr_we,
   input  logic         en_we,
   input  logic         dis_we,
   input  logic         mask_we,
   input  logic [N-1:0] wvec,
   output logic [N-1:0] raw_o,
   output logic [N-1:0] en_o,
   output logic [N-1:0] stat_o,
   output logic         irq_o
);
   logic [N-1:0] raw_q, en_q;

   // a new acknowledge outranks a clear of the same bit
   always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~(clr_we ? wvec : '0)) | ack_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       en_q <= '0;
      else if (mask_we) en_q <= wvec;
      else if (en_we)   en_q <= en_q | wvec;
      else if (dis_we)  en_q <= en_q & ~wvec;
   end

   assign raw_o  = raw_q;
   assign en_o   = en_q;
   assign stat_o = raw_q & en_q;
   assign irq_o  = |stat_o;
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic [N-1:0] wvec,
   input  logic [N-1:0] peer_clr,
   output logic [N-1:0] db_o
);
   logic [N-1:0] db_q;

   always_ff @(posedge clk) begin
      if (!rst_n) db_q <= '0;
      else        db_q <= (db_q & ~peer_clr) | (set_we ? wvec : '0);
   end

   assign db_o = db_q;
endmodule

// File: rtl/ipc_slot_mailbox.sv
module ipc_slot_mailbox
   import mbx_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int MSG_WORDS = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    l_addr,
   input  logic                 l_we,
   input  logic [DATA_W-1:0]    l_wdata,
   output logic [DATA_W-1:0]    l_rdata,
   input  logic [ADDR_W-1:0]    r_addr,
   input  logic                 r_we,
   input  logic [DATA_W-1:0]    r_wdata,
   output logic [DATA_W-1:0]    r_rdata,
   input  logic [NUM_SLOTS-1:0] r_ack,
   input  logic [NUM_SLOTS-1:0] r_db_clr,
   output logic [NUM_SLOTS-1:0] db_to_peer,
   output logic                 irq
);
   localparam int SW       = $clog2(NUM_SLOTS);
   localparam int SLOT_AW  = SW + 6;
   localparam int SLOT_SPAN = NUM_SLOTS * WIN_BYTES;

   // elaboration-time parameter checks
   if (NUM_SLOTS < 2 || NUM_SLOTS > DATA_W) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 2..DATA_W");
   end
   if (MSG_WORDS < 1 || MSG_WORDS >= WIN_WORDS) begin : g_bad_words
      $error("MSG_WORDS must lie in 1..15");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W < 13 || ADDR_W - 1 < SLOT_AW) begin : g_bad_addr
      $error("ADDR_W too small for the slot and control regions");
   end

   function automatic logic slot_hit(input logic [ADDR_W-1:0] a);
      return !a[ADDR_W-1] && (a[1:0] == 2'b00)
             && (32'(a[ADDR_W-2:0]) < 32'(SLOT_SPAN))
             && (a[5:2] <= 4'(MSG_WORDS));
   endfunction

   // ---------------- address decode ----------------
   logic            l_hit, r_hit;
   logic [SW-1:0]   l_slot, r_slot;
   logic [3:0]      l_word, r_word;
   ctrl_sel_e       csel;

   assign l_hit  = slot_hit(l_addr);
   assign r_hit  = slot_hit(r_addr);
   assign l_slot = l_addr[SLOT_AW-1:6];
   assign r_slot = r_addr[SLOT_AW-1:6];
   assign l_word = l_addr[5:2];
   assign r_word = r_addr[5:2];

   always_comb begin
      csel = CR_NONE;
      if (l_addr[ADDR_W-1] && l_addr[1:0] == 2'b00
          && 32'(l_addr[ADDR_W-2:0]) < 32'h1000)
         csel = decode_ctrl(l_addr[11:0]);
   end

   // ---------------- slot array ----------------
   logic [MSG_WORDS:0][DATA_W-1:0] slot_words [NUM_SLOTS];
   logic [NUM_SLOTS-1:0]           slot_auto;
   logic [NUM_SLOTS-1:0]           slot_ack_irq;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic l_sel, r_sel;
      assign l_sel = l_we && l_hit && (l_slot == SW'(s));
      assign r_sel = r_we && r_hit && (r_slot == SW'(s));

      mbx_slot #(
         .DATA_W    (DATA_W),
         .MSG_WORDS (MSG_WORDS)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .l_we      (l_sel),
         .l_word    (l_word),
         .l_wdata   (l_wdata),
         .r_we      (r_sel),
         .r_word    (r_word),
         .r_wdata   (r_wdata),
         .ack_in    (r_ack[s]),
         .words_o   (slot_words[s]),
         .auto_o    (slot_auto[s]),
         .ack_irq_o (slot_ack_irq[s])
      );
   end

   // ---------------- acknowledge interrupt ----------------
   logic [NUM_SLOTS-1:0] ack_raw, ack_en, ack_stat, wvec;
   assign wvec = l_wdata[NUM_SLOTS-1:0];

   mbx_ack_irq #(.N(NUM_SLOTS)) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_set (slot_ack_irq),
      .clr_we  (l_we && csel == CR_CLR),
      .en_we   (l_we && csel == CR_EN),
      .dis_we  (l_we && csel == CR_DIS),
      .mask_we (l_we && csel == CR_MASK),
      .wvec    (wvec),
      .raw_o   (ack_raw),
      .en_o    (ack_en),
      .stat_o  (ack_stat),
      .irq_o   (irq)
   );

   // ---------------- doorbell ----------------
   mbx_doorbell #(.N(NUM_SLOTS)) u_db (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (l_we && csel == CR_DB),
      .wvec     (wvec),
      .peer_clr (r_db_clr),
      .db_o     (db_to_peer)
   );

   // ---------------- registered read paths ----------------
   logic [DATA_W-1:0] l_rd_nxt, r_rd_nxt;

   always_comb begin
      l_rd_nxt = '0;
      if (l_hit) begin
         l_rd_nxt = slot_words[l_slot][l_word];
      end else begin
         case (csel)
            CR_RAW:          l_rd_nxt = DATA_W'(ack_raw);
            CR_MASK, CR_EN:  l_rd_nxt = DATA_W'(ack_en);
            CR_STAT:         l_rd_nxt = DATA_W'(ack_stat);
            CR_DB:           l_rd_nxt = DATA_W'(db_to_peer);
            default:         l_rd_nxt = '0;
         endcase
      end
   end

   always_comb begin
      r_rd_nxt = '0;
      if (r_hit) r_rd_nxt = slot_words[r_slot][r_word];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         l_rdata <= '0;
         r_rdata <= '0;
      end else begin
         l_rdata <= l_rd_nxt;
         r_rdata <= r_rd_nxt;
      end
   end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
   import mbx_pkg::*;
#(
   parameter int N      = 32,
   parameter int ADDR_W = 13,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_we,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_wdata,
   input logic [N-1:0]      r_ack,
   input logic [N-1:0]      r_db_clr,
   input logic [N-1:0]      raw_vec,
   input logic [N-1:0]      en_vec,
   input logic [N-1:0]      auto_vec,
   input logic [N-1:0]      db_to_peer,
   input logic              irq
);
   localparam logic [ADDR_W-1:0] A_EN  = {1'b1, (ADDR_W-1)'(OFF_EN)};
   localparam logic [ADDR_W-1:0] A_DIS = {1'b1, (ADDR_W-1)'(OFF_DIS)};
   localparam logic [ADDR_W-1:0] A_CLR = {1'b1, (ADDR_W-1)'(OFF_CLR)};
   localparam logic [ADDR_W-1:0] A_DB  = {1'b1, (ADDR_W-1)'(OFF_DB)};

   logic [N-1:0] wv;
   assign wv = l_wdata[N-1:0];

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!irq && db_to_peer == '0 && en_vec == '0 && raw_vec == '0)); // R1

   AST_AUTO_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      ((r_ack & auto_vec) != '0) |=> ((raw_vec & ~$past(raw_vec) & $past(r_ack & auto_vec)) == '0)); // R5

   AST_IRQ_ACK_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      ((r_ack & ~auto_vec) != '0) |=> ((raw_vec & $past(r_ack & ~auto_vec)) == $past(r_ack & ~auto_vec))); // R6

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (l_we && l_addr == A_EN) |=> ((en_vec & $past(wv)) == $past(wv))); // R7

   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (l_we && l_addr == A_DIS) |=> ((en_vec & $past(wv)) == '0)); // R7

   AST_CLR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (l_we && l_addr == A_CLR) |=> ((raw_vec & $past(wv & ~r_ack)) == '0)); // R9

   AST_DB_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (l_we && l_addr == A_DB) |=> ((db_to_peer & $past(wv)) == $past(wv))); // R10
endmodule

bind ipc_slot_mailbox mbx_checker #(
   .N      (NUM_SLOTS),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .l_we       (l_we),
   .l_addr     (l_addr),
   .l_wdata    (l_wdata),
   .r_ack      (r_ack),
   .r_db_clr   (r_db_clr),
   .raw_vec    (ack_raw),
   .en_vec     (ack_en),
   .auto_vec   (slot_auto),
   .db_to_peer (db_to_peer),
   .irq        (irq)
);

// File: tb/tb_ipc_slot_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_slot_mailbox;
   localparam int NS = 32;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] l_addr, r_addr;
   logic          l_we, r_we;
   logic [31:0]   l_wdata, r_wdata, l_rdata, r_rdata;
   logic [NS-1:0] r_ack, r_db_clr, db_to_peer;
   logic          irq;

   always #5 clk = ~clk;

   ipc_slot_mailbox dut (
      .clk(clk), .rst_n(rst_n),
      .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .r_ack(r_ack), .r_db_clr(r_db_clr), .db_to_peer(db_to_peer), .irq(irq)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic        rd_pend = 1'b0;
   bit          finished = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   function automatic logic [AW-1:0] sa(input int s, input int w);
      return AW'(s * 64 + w * 4);
   endfunction
   function automatic logic [AW-1:0] ca(input int off);
      return {1'b1, 12'(off)};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // driver: present address and push the expectation
   task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      l_we = 1'b0; l_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_pend = 1'b1;
      @(negedge clk);
      rd_pend = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      l_we = 1'b1; l_addr = a; l_wdata = d;
      @(negedge clk);
      l_we = 1'b0;
   endtask

   task automatic rwr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      r_we = 1'b1; r_addr = a; r_wdata = d;
      @(negedge clk);
      r_we = 1'b0;
   endtask

   task automatic rrd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      r_addr = a;
      @(posedge clk);
      #1 chk(r_rdata, exp, tag);
   endtask

   task automatic ack(input logic [NS-1:0] v);
      @(negedge clk);
      r_ack = v;
      @(negedge clk);
      r_ack = '0;
   endtask

   // monitor: pop and compare one cycle after each read address
   initial begin
      forever begin
         @(posedge clk);
         if (rd_pend) begin
            logic [31:0] e;
            string       t;
            #1;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(l_rdata, e, t);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; l_we = 1'b0; r_we = 1'b0;
      l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
      r_ack = '0; r_db_clr = '0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(sa(0, 0), 32'h10, "R1 slot0 mode");
      rd(sa(31, 0), 32'h10, "R1 slot31 mode");
      rd(sa(5, 1), 32'h0, "R1 slot5 data");
      rd(ca(12'h400), 32'h0, "R1 raw");
      rd(ca(12'h500), 32'h0, "R1 enable");
      chk({31'b0, irq}, 32'h0, "R1 irq");
      chk(db_to_peer, 32'h0, "R1 doorbell");

      // R2 message words and window layout
      for (int w = 1; w <= 8; w++) wr(sa(3, w), 32'hA300_0000 | w);
      for (int w = 1; w <= 8; w++) rd(sa(3, w), 32'hA300_0000 | w, "R2 slot3 word");
      wr(sa(31, 8), 32'hDEAD_0031);
      rd(sa(31, 8), 32'hDEAD_0031, "R2 slot31 last word");
      wr(sa(3, 9), 32'hFFFF_FFFF);
      rd(sa(3, 9), 32'h0, "R2 word9 unmapped");
      rd(sa(4, 0), 32'h10, "R2 no alias into slot4");
      rd(sa(3, 8), 32'hA300_0008, "R2 slot3 word8 kept");

      // R3 mode word fields
      wr(sa(3, 0), 32'hFFFF_FF21);
      rd(sa(3, 0), 32'h21, "R3 mode fields");

      // R4 remote port
      rrd(sa(3, 2), 32'hA300_0002, "R4 remote read");
      rwr(sa(3, 1), 32'h55);
      rd(sa(3, 1), 32'h55, "R4 remote write");
      @(negedge clk);
      l_we = 1'b1; l_addr = sa(3, 1); l_wdata = 32'h111;
      r_we = 1'b1; r_addr = sa(3, 1); r_wdata = 32'h222;
      @(negedge clk);
      l_we = 1'b0; r_we = 1'b0;
      rd(sa(3, 1), 32'h222, "R4 collision remote wins");
      rwr(ca(12'h0C4), 32'h999);
      rd(sa(3, 1), 32'h222, "R4 remote ctrl write ignored");

      // R5 automatic acknowledge
      wr(ca(12'h500), 32'hFFFF_FFFF);
      rd(ca(12'h500), 32'hFFFF_FFFF, "R7 enable all");
      ack(32'h1 << 3);
      rd(sa(3, 0), 32'h11, "R5 auto ack to idle");
      rd(ca(12'h400), 32'h0, "R5 raw unchanged");
      chk({31'b0, irq}, 32'h0, "R5 no irq");

      // R6 interrupt-mode acknowledge
      wr(sa(7, 0), 32'h20);
      ack(32'h1 << 7);
      chk({31'b0, irq}, 32'h1, "R8 irq raised");
      rd(sa(7, 0), 32'h80, "R6 state acknowledged");
      rd(ca(12'h400), 32'h80, "R6 raw bit set");
      rd(ca(12'h408), 32'h80, "R8 status");

      // R7 enable/disable/mask
      wr(ca(12'h504), 32'h80);
      rd(ca(12'h500), 32'hFFFF_FF7F, "R7 disable bit");
      rd(ca(12'h408), 32'h0, "R8 status masked");
      chk({31'b0, irq}, 32'h0, "R8 irq masked");
      rd(ca(12'h400), 32'h80, "R8 raw kept");
      rd(ca(12'h504), 32'h0, "R7 disable reads zero");
      wr(ca(12'h404), 32'h80);
      rd(ca(12'h404), 32'h80, "R7 mask overwrite");
      chk({31'b0, irq}, 32'h1, "R8 irq after mask");

      // R9 clear
      wr(ca(12'h40C), 32'hFFFF_FFFF);
      rd(ca(12'h400), 32'h0, "R9 clear all");
      chk({31'b0, irq}, 32'h0, "R9 irq after clear");
      rd(ca(12'h40C), 32'h0, "R9 clear reads zero");
      @(negedge clk);
      l_we = 1'b1; l_addr = ca(12'h40C); l_wdata = 32'h200;
      r_ack = 32'h200;
      @(negedge clk);
      l_we = 1'b0; r_ack = '0;
      rd(ca(12'h400), 32'h200, "R9 ack beats clear");
      wr(ca(12'h40C), 32'h200);
      rd(ca(12'h400), 32'h0, "R9 single clear");

      // R10 doorbell
      wr(ca(12'h420), 32'h4);
      chk(db_to_peer, 32'h4, "R10 doorbell set");
      wr(ca(12'h420), 32'h1);
      chk(db_to_peer, 32'h5, "R10 doorbell accumulate");
      @(negedge clk) r_db_clr = 32'h4;
      @(negedge clk) r_db_clr = '0;
      chk(db_to_peer, 32'h1, "R10 peer clear");
      rd(ca(12'h420), 32'h1, "R10 doorbell read");

      repeat (3) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule